// File: doc/BRIEF.md
# Core control register bank

This block is the register file that sits between a 32-bit system bus and a streaming processing core. Software uses it to start and stop the core, to choose the data direction, and to set the sample formats used on the way in and on the way out. It also holds seven standard run-time parameters, passes coefficient words on to external loader memories, and keeps a set of general-purpose user parameters.

Each core owns a 24-bit register address window. The upper bits of the full bus address pick the core, and that decode happens outside this block. The bank sees a chip select, a word address within its window, a write strobe with data, and a read strobe. It answers every selected access with a one-cycle acknowledge. The control word is split into separate enable, direction and format outputs. The standard parameters appear as full-width outputs for the datapath.

A system reset restores the control word and the standard parameters. The user parameters keep their contents, so a configuration that software loaded earlier survives when the core is restarted.

Top module: `core_regbank`

## Requirements
- R1: An access is a cycle in which `bus_sel` is high and `bus_wr` or `bus_rd` is high. `bus_ack` is high for exactly one clock, in the cycle after each access, and is low after every cycle that is not an access.
- R2: Word address 0 is the control word. Bit 0 is the core enable, bit 1 is the direction (1 = playback, 0 = acquisition), bits 11:8 are the input format code and bits 15:12 are the output format code. All other bits read back as zero. The four fields drive `ctl_enable`, `ctl_play`, `ctl_in_fmt` and `ctl_out_fmt` from the cycle after the write.
- R3: Word addresses 1 to 7 are full 32-bit read/write parameters, in this order: decimation minus one (1), gain (2), rate in Hz (3), ratio (4), frame length minus one (5), frequency (6) and flags (7). Each drives its `prm_*` output from the cycle after the write.
- R4: Word addresses 16 to 47 are 32 user parameter words. Each is read/write over the full 32 bits.
- R5: A write to word addresses 8 to 15 raises `coef_load` for one clock in the acknowledge cycle. In that cycle `coef_slot` equals the address minus 8 and `coef_data` equals the written word. Reads of these addresses return zero.
- R6: Word addresses 48 and above read as zero. Writes to them change no register.
- R7: While `rst` is high at a clock edge, the control word and addresses 1 to 7 clear to zero, `bus_ack` and `coef_load` go low, and bus strobes are ignored. The user words keep their contents.
- R8: While `bus_sel` is low, the strobes have no effect: no acknowledge, no load strobe and no register change.
- R9: `bus_rdata` is zero in every cycle except the acknowledge cycle of a read.
- R10: If a single access carries both a write and a read to the same address, the write takes effect and the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Chip select for this core's window |
| bus_addr | input | 24 | Word address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| ctl_enable | output | 1 | Core enable |
| ctl_play | output | 1 | 1 = playback, 0 = acquisition |
| ctl_in_fmt | output | 4 | Input format code |
| ctl_out_fmt | output | 4 | Output format code |
| prm_decim_m1 | output | 32 | Decimation minus one |
| prm_gain | output | 32 | Gain |
| prm_rate | output | 32 | Rate in Hz |
| prm_ratio | output | 32 | Ratio, fractional binary |
| prm_frame_m1 | output | 32 | Frame length minus one |
| prm_freq | output | 32 | Frequency, fractional binary |
| prm_flags | output | 32 | Flags |
| coef_load | output | 1 | Coefficient load strobe |
| coef_slot | output | 3 | Coefficient slot index |
| coef_data | output | 32 | Coefficient word |

## Verification
The assertions check on every cycle the following rules:
- the acknowledge follows an access one cycle later and follows nothing else;
- read data stays zero outside a read acknowledge;
- the load strobe follows only writes to the loader range, and its slot matches the address;
- reset clears the control outputs and parameter outputs;
- control outputs hold their value unless the control word is written.

Other behaviours need the bench's scenarios, because they depend on stored contents over many accesses:
- read-back of every register class;
- zero reads of the unmapped and loader ranges;
- writes to unmapped addresses leaving every register unchanged;
- user words surviving a reset;
- a combined write and read returning the old value.

// File: rtl/core_regbank_pkg.sv
package core_regbank_pkg;

  typedef enum logic [2:0] {
    RGN_SYS  = 3'd0,
    RGN_STD  = 3'd1,
    RGN_COEF = 3'd2,
    RGN_USER = 3'd3,
    RGN_NONE = 3'd4
  } region_e;

  localparam int unsigned STD_FIRST  = 1;
  localparam int unsigned STD_LAST   = 7;
  localparam int unsigned COEF_FIRST = 8;
  localparam int unsigned USER_BASE  = 16;

  localparam int unsigned SYS_EN_BIT   = 0;
  localparam int unsigned SYS_PLAY_BIT = 1;
  localparam int unsigned SYS_IFMT_LSB = 8;
  localparam int unsigned SYS_OFMT_LSB = 12;
  localparam int unsigned FMT_W        = 4;
  localparam int unsigned SLOT_W       = 3;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import core_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned USER_N = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] A_STD_LO  = ADDR_W'(STD_FIRST);
  localparam logic [ADDR_W-1:0] A_STD_HI  = ADDR_W'(STD_LAST);
  localparam logic [ADDR_W-1:0] A_COEF_LO = ADDR_W'(COEF_FIRST);
  localparam logic [ADDR_W-1:0] A_USER_LO = ADDR_W'(USER_BASE);
  localparam logic [ADDR_W-1:0] A_USER_HI = ADDR_W'(USER_BASE + USER_N - 1);

  logic [ADDR_W-1:0] user_off;
  assign user_off = addr - A_USER_LO;

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    if (addr == '0) begin
      region = RGN_SYS;
    end else if (addr >= A_STD_LO && addr <= A_STD_HI) begin
      region = RGN_STD;
      idx    = IDX_W'(addr[SLOT_W-1:0]);
    end else if (addr >= A_COEF_LO && addr < A_USER_LO) begin
      region = RGN_COEF;
      idx    = IDX_W'(addr[SLOT_W-1:0]);
    end else if (addr >= A_USER_LO && addr <= A_USER_HI) begin
      region = RGN_USER;
      idx    = user_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import core_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  region_e               region,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rd_val,
  output logic                  sys_en,
  output logic                  sys_play,
  output logic [FMT_W-1:0]      sys_ifmt,
  output logic [FMT_W-1:0]      sys_ofmt,
  output logic [STD_LAST:STD_FIRST][DATA_W-1:0] std_out
);
  logic [DATA_W-1:0] std_q [STD_FIRST:STD_LAST];
  logic [DATA_W-1:0] sys_word;

  always_comb begin
    sys_word = '0;
    sys_word[SYS_EN_BIT]                       = sys_en;
    sys_word[SYS_PLAY_BIT]                     = sys_play;
    sys_word[SYS_IFMT_LSB +: FMT_W]            = sys_ifmt;
    sys_word[SYS_OFMT_LSB +: FMT_W]            = sys_ofmt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_en   <= 1'b0;
      sys_play <= 1'b0;
      sys_ifmt <= '0;
      sys_ofmt <= '0;
    end else if (wr_en && region == RGN_SYS) begin
      sys_en   <= wdata[SYS_EN_BIT];
      sys_play <= wdata[SYS_PLAY_BIT];
      sys_ifmt <= wdata[SYS_IFMT_LSB +: FMT_W];
      sys_ofmt <= wdata[SYS_OFMT_LSB +: FMT_W];
    end
  end

  for (genvar g = STD_FIRST; g <= STD_LAST; g++) begin : g_std
    always_ff @(posedge clk) begin
      if (rst) begin
        std_q[g] <= '0;
      end else if (wr_en && region == RGN_STD && idx == IDX_W'(g)) begin
        std_q[g] <= wdata;
      end
    end
    assign std_out[g] = std_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val <= '0;
    end else if (rd_en) begin
      case (region)
        RGN_SYS: rd_val <= sys_word;
        RGN_STD: rd_val <= std_q[idx[SLOT_W-1:0] == '0 ? STD_FIRST : idx[SLOT_W-1:0]];
        default: rd_val <= '0;
      endcase
    end
  end
endmodule

// File: rtl/regbank_user.sv
module regbank_user #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/regbank_coef.sv
module regbank_coef
  import core_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              load,
  output logic [SLOT_W-1:0] slot,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load <= 1'b0;
      slot <= '0;
      data <= '0;
    end else begin
      load <= hit;
      if (hit) begin
        slot <= idx[SLOT_W-1:0];
        data <= wdata;
      end
    end
  end
endmodule

// File: rtl/core_regbank.sv
module core_regbank
  import core_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned USER_N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              ctl_enable,
  output logic              ctl_play,
  output logic [3:0]        ctl_in_fmt,
  output logic [3:0]        ctl_out_fmt,
  output logic [DATA_W-1:0] prm_decim_m1,
  output logic [DATA_W-1:0] prm_gain,
  output logic [DATA_W-1:0] prm_rate,
  output logic [DATA_W-1:0] prm_ratio,
  output logic [DATA_W-1:0] prm_frame_m1,
  output logic [DATA_W-1:0] prm_freq,
  output logic [DATA_W-1:0] prm_flags,
  output logic              coef_load,
  output logic [2:0]        coef_slot,
  output logic [DATA_W-1:0] coef_data
);
  localparam int unsigned UIDX_W = (USER_N > 1) ? $clog2(USER_N) : 1;
  localparam int unsigned IDX_W  = (UIDX_W > SLOT_W) ? UIDX_W : SLOT_W;

  region_e           region;
  region_e           region_q;
  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_en, acc;
  logic              ack_q, rd_q;
  logic [DATA_W-1:0] ctrl_rd, user_rd;
  logic [STD_LAST:STD_FIRST][DATA_W-1:0] std_out;

  assign wr_en = bus_sel && bus_wr && !rst;
  assign rd_en = bus_sel && bus_rd && !rst;
  assign acc   = wr_en || rd_en;

  regbank_decode #(.ADDR_W(ADDR_W), .USER_N(USER_N), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .region(region), .idx(idx)
  );

  regbank_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .region(region),
    .idx(idx), .wdata(bus_wdata), .rd_val(ctrl_rd),
    .sys_en(ctl_enable), .sys_play(ctl_play),
    .sys_ifmt(ctl_in_fmt), .sys_ofmt(ctl_out_fmt), .std_out(std_out)
  );

  regbank_user #(.DATA_W(DATA_W), .DEPTH(USER_N), .IDX_W(UIDX_W)) u_user (
    .clk(clk),
    .we(wr_en && region == RGN_USER),
    .re(rd_en && region == RGN_USER),
    .idx(idx[UIDX_W-1:0]),
    .wdata(bus_wdata),
    .rdata(user_rd)
  );

  regbank_coef #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_coef (
    .clk(clk), .rst(rst),
    .hit(wr_en && region == RGN_COEF),
    .idx(idx), .wdata(bus_wdata),
    .load(coef_load), .slot(coef_slot), .data(coef_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      region_q <= RGN_NONE;
    end else begin
      ack_q    <= acc;
      rd_q     <= rd_en;
      region_q <= region;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = !rd_q ? '0 : (region_q == RGN_USER) ? user_rd : ctrl_rd;

  assign prm_decim_m1 = std_out[1];
  assign prm_gain     = std_out[2];
  assign prm_rate     = std_out[3];
  assign prm_ratio    = std_out[4];
  assign prm_frame_m1 = std_out[5];
  assign prm_freq     = std_out[6];
  assign prm_flags    = std_out[7];
endmodule

// File: rtl/regbank_checks.sv
module regbank_checks #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ack,
  input logic              ctl_enable,
  input logic [3:0]        ctl_in_fmt,
  input logic [3:0]        ctl_out_fmt,
  input logic [DATA_W-1:0] prm_gain,
  input logic              coef_load,
  input logic [2:0]        coef_slot
);
  logic access, coef_hit, sys_hit, read_acc;
  assign access   = bus_sel && (bus_wr || bus_rd) && !rst;
  assign read_acc = bus_sel && bus_rd && !rst;
  assign coef_hit = bus_sel && bus_wr && !rst &&
                    bus_addr >= ADDR_W'(8) && bus_addr <= ADDR_W'(15);
  assign sys_hit  = bus_sel && bus_wr && bus_addr == '0;

  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (rst)
    access |=> bus_ack);
  assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (rst)
    !access |=> !bus_ack);
  assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !read_acc |=> bus_rdata == '0);
  assert_coef_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    coef_hit |=> (coef_load && coef_slot == $past(bus_addr[2:0])));
  assert_coef_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !coef_hit |=> !coef_load);
  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!ctl_enable && ctl_in_fmt == '0 && prm_gain == '0 && !bus_ack && !coef_load));
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sys_hit |=> ($stable(ctl_enable) && $stable(ctl_in_fmt) && $stable(ctl_out_fmt)));
endmodule

bind core_regbank regbank_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
  .ctl_enable(ctl_enable), .ctl_in_fmt(ctl_in_fmt), .ctl_out_fmt(ctl_out_fmt),
  .prm_gain(prm_gain), .coef_load(coef_load), .coef_slot(coef_slot)
);

// File: tb/tb_core_regbank.sv
`timescale 1ns/1ps
module tb_core_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr, bus_rd;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        ctl_enable, ctl_play;
  logic [3:0]  ctl_in_fmt, ctl_out_fmt;
  logic [31:0] prm_decim_m1, prm_gain, prm_rate, prm_ratio, prm_frame_m1, prm_freq, prm_flags;
  logic        coef_load;
  logic [2:0]  coef_slot;
  logic [31:0] coef_data;

  always #2.5 clk = ~clk;

  core_regbank dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .ctl_enable(ctl_enable), .ctl_play(ctl_play),
    .ctl_in_fmt(ctl_in_fmt), .ctl_out_fmt(ctl_out_fmt),
    .prm_decim_m1(prm_decim_m1), .prm_gain(prm_gain), .prm_rate(prm_rate),
    .prm_ratio(prm_ratio), .prm_frame_m1(prm_frame_m1), .prm_freq(prm_freq),
    .prm_flags(prm_flags), .coef_load(coef_load), .coef_slot(coef_slot),
    .coef_data(coef_data)
  );

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [31:0] model [0:47];
  logic        user_known [16:47];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [23:0] a);
    if (a < 24'd8)  return model[a[5:0]];
    if (a < 24'd16) return 32'h0;
    if (a < 24'd48) return model[a[5:0]];
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [23:0] a, input logic [31:0] d);
    if (a == 24'd0) model[0] = d & 32'h0000_FF03;
    else if (a < 24'd8) model[a[5:0]] = d;
    else if (a >= 24'd16 && a < 24'd48) begin
      model[a[5:0]] = d;
      user_known[a[5:0]] = 1'b1;
    end
  endfunction

  function automatic bit known(input logic [23:0] a);
    if (a >= 24'd16 && a < 24'd48) return user_known[a[5:0]];
    return 1'b1;
  endfunction

  // One access starting on a falling edge; results sampled on the next falling edge.
  task automatic access(input bit sel, input bit wr, input bit rd,
                        input logic [23:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp_rd;
    bit          acc, chk_rd;
    exp_rd = (sel && rd) ? exp_read(a) : 32'h0;
    chk_rd = !(sel && rd) || known(a);
    acc    = sel && (wr || rd);
    bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    check(bus_ack == acc, {req, " ack (R1)"}, 32'(bus_ack), 32'(acc));
    if (chk_rd) check(bus_rdata == exp_rd, {req, " rdata (R9)"}, bus_rdata, exp_rd);
    if (sel && wr && a >= 24'd8 && a < 24'd16) begin
      check(coef_load == 1'b1, {req, " coef_load (R5)"}, 32'(coef_load), 32'd1);
      check(coef_slot == a[2:0] && coef_data == d, {req, " coef slot/data (R5)"},
            {coef_slot, coef_data[28:0]}, {a[2:0], d[28:0]});
    end else begin
      check(coef_load == 1'b0, {req, " coef idle (R5)"}, 32'(coef_load), 32'd0);
    end
    if (sel && wr) model_write(a, d);
  endtask

  task automatic check_outputs(input string req);
    check(ctl_enable == model[0][0] && ctl_play == model[0][1], {req, " en/play (R2)"},
          {30'd0, ctl_play, ctl_enable}, {30'd0, model[0][1:0]});
    check(ctl_in_fmt == model[0][11:8] && ctl_out_fmt == model[0][15:12], {req, " fmt (R2)"},
          {24'd0, ctl_out_fmt, ctl_in_fmt}, {24'd0, model[0][15:8]});
    check(prm_decim_m1 == model[1], {req, " decim (R3)"}, prm_decim_m1, model[1]);
    check(prm_gain == model[2], {req, " gain (R3)"}, prm_gain, model[2]);
    check(prm_rate == model[3], {req, " rate (R3)"}, prm_rate, model[3]);
    check(prm_ratio == model[4], {req, " ratio (R3)"}, prm_ratio, model[4]);
    check(prm_frame_m1 == model[5], {req, " frame (R3)"}, prm_frame_m1, model[5]);
    check(prm_freq == model[6], {req, " freq (R3)"}, prm_freq, model[6]);
    check(prm_flags == model[7], {req, " flags (R3)"}, prm_flags, model[7]);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 64; i++) access(1'b1, 1'b0, 1'b1, 24'(i), 32'h0, req);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 48; i++) model[i] = 32'h0;
    for (int i = 16; i < 48; i++) user_known[i] = 1'b0;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check(bus_ack == 1'b0 && coef_load == 1'b0, "reset idle (R7)", 32'(bus_ack), 32'd0);
    rst = 1'b0;
    check_outputs("after reset R7");

    // R2: control word fields and masking
    access(1, 1, 0, 24'd0, 32'hFFFF_FFFF, "R2 write all ones");
    check_outputs("R2 ones");
    access(1, 0, 1, 24'd0, 32'h0, "R2 readback masked");
    access(1, 1, 0, 24'd0, 32'h0000_A502, "R2 play fmt");
    check_outputs("R2 pattern");

    // R3: standard parameters
    for (int i = 1; i < 8; i++) access(1, 1, 0, 24'(i), 32'h1111_0000 * i + 32'(i), "R3 write");
    check_outputs("R3 params");
    for (int i = 1; i < 8; i++) access(1, 0, 1, 24'(i), 32'h0, "R3 read");

    // R4: user words, boundaries
    access(1, 1, 0, 24'd16, 32'hDEAD_0016, "R4 first user");
    access(1, 1, 0, 24'd47, 32'hBEEF_0047, "R4 last user");
    access(1, 0, 1, 24'd16, 32'h0, "R4 read first");
    access(1, 0, 1, 24'd47, 32'h0, "R4 read last");

    // R5: coefficient slots
    for (int i = 8; i < 16; i++) access(1, 1, 0, 24'(i), 32'hC0EF_0000 + 32'(i), "R5 load");
    access(1, 0, 1, 24'd12, 32'h0, "R5 read zero");

    // R6: unmapped space
    access(1, 1, 0, 24'd48, 32'h1234_5678, "R6 write 48");
    access(1, 1, 0, 24'hFFFFFF, 32'h8765_4321, "R6 write top");
    access(1, 0, 1, 24'd48, 32'h0, "R6 read 48");
    access(1, 0, 1, 24'h800010, 32'h0, "R6 read alias");
    check_outputs("R6 nothing changed");

    // R8: select low
    access(0, 1, 0, 24'd2, 32'hBAD0_BAD0, "R8 write no sel");
    access(0, 1, 0, 24'd9, 32'hBAD0_BAD1, "R8 coef no sel");
    access(0, 0, 1, 24'd2, 32'h0, "R8 read no sel");
    check_outputs("R8 unchanged");

    // R10: combined write and read
    access(1, 1, 1, 24'd3, 32'h5555_AAAA, "R10 std");
    access(1, 1, 1, 24'd20, 32'h0F0F_F0F0, "R10 user");
    access(1, 0, 1, 24'd20, 32'h0, "R10 user new value");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [23:0] a;
      int unsigned r;
      r = $urandom % 16;
      a = (r == 0) ? 24'($urandom) : 24'($urandom % 56);
      access(($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 2) == 1,
             a, $urandom, "random R4");
      if ((n % 50) == 0) check_outputs("random R3");
    end
    read_all("R6 sweep");

    // R7: reset keeps user words, clears the rest
    rst = 1'b1;
    bus_sel = 1; bus_wr = 1; bus_addr = 24'd17; bus_wdata = 32'hFFFF_0000;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    check(bus_ack == 1'b0, "R7 no ack in reset", 32'(bus_ack), 32'd0);
    check_outputs("R7 cleared");
    read_all("R7 user kept");

    // R1: back-to-back accesses each acknowledged
    access(1, 0, 1, 24'd1, 32'h0, "R1 b2b a");
    access(1, 0, 1, 24'd16, 32'h0, "R1 b2b b");
    @(negedge clk);
    check(bus_ack == 1'b0, "R1 single pulse", 32'(bus_ack), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule